// File: doc/BRIEF.md
# Frame-Synchronised PCM Serial Port

This block moves one audio sample per frame between a parallel register interface and a serial PCM bus. A fast system clock oversamples the external bit clock, the frame sync and the serial receive line through synchronisers. A rising frame sync starts a slot. The block then shifts the latched transmit word out MSB first, and it shifts the receive bits into a word. That word is published with a one-cycle strobe.

A slot is 16 bits for linear samples or 8 bits for companded samples. Two clock-edge arrangements are supported. Framing is either non-delayed, where the first bit comes straight from the frame sync, or delayed, where it comes one bit period later. The transmit driver is enabled only inside the slot, so the line can share a bus through an external tri-state buffer. A new frame sync that arrives in the middle of a slot abandons that slot and begins a fresh one.

Top module: `pcm_frame_port`

## Requirements
- R1: After reset, `tx_oe`, `tx_data`, `rx_valid` and `rx_word` are all zero.
- R2: A frame begins when a rising frame sync is seen. `tx_word` and the three mode inputs are latched at that moment, and changes to them during the slot have no effect on that frame.
- R3: `slot_long`=1 selects a 16-bit slot and `slot_long`=0 selects an 8-bit slot. Bits travel MSB first in both directions.
- R4: In a 16-bit slot the line carries `tx_word[15:2]` followed by two zero bits. In an 8-bit slot it carries `tx_word[7:0]`.
- R5: With `edge_alt`=0, data is launched on the rising bit-clock edge and received bits are captured on the falling edge. With `edge_alt`=1 both edges are swapped. The transmit bit holds steady between launch edges.
- R6: With `frame_delayed`=0, `tx_oe` rises and the first bit is driven as soon as the frame sync rise is seen, without waiting for a bit-clock edge. The first receive bit is captured on the next capture edge.
- R7: With `frame_delayed`=1, the driver stays off until the first launch edge after the frame sync rise. That edge drives the first bit, and the first receive bit is captured on the capture edge that follows.
- R8: `tx_oe` falls on the capture edge of the slot's last bit, and `tx_data` is 0 whenever `tx_oe` is 0.
- R9: After the last bit of a slot is captured, `rx_valid` pulses for exactly one cycle. `rx_word` holds the slot MSB first: all 16 bits for a long slot, or the 8 bits in `rx_word[7:0]` with the upper byte zero for a short slot. The word holds until the next publish.
- R10: A frame sync rise during a slot abandons it: no `rx_valid` is produced for that slot and a new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Asynchronous PCM bit clock |
| fsync_in | input | 1 | Asynchronous frame sync |
| rx_in | input | 1 | Serial receive data |
| tx_word | input | 16 | Parallel word to transmit |
| slot_long | input | 1 | 1: 16-bit slot, 0: 8-bit slot |
| edge_alt | input | 1 | 0: launch on rise, capture on fall; 1: swapped |
| frame_delayed | input | 1 | 1: first bit one period after frame sync |
| tx_data | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Enable for the external transmit driver |
| rx_word | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |

## Verification
The assertions assume that the bit clock and frame sync change slowly enough against the system clock that each level survives the synchroniser. They also assume that rising and falling bit-clock events never coincide, and that the receive bit settles before the capture edge. The stimulus plays the bus master. It holds each bit-clock level for eight system cycles, and it changes frame sync and receive data only together with a launch edge. It changes modes only while the port is idle or at a point inside a slot where the latched copy must win. Every bit is checked just before the capture edge that would sample it.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int SLOT_LONG   = 16;
    localparam int SLOT_SHORT  = 8;
    localparam int SAMPLE_BITS = 14;
    localparam int CNT_W       = $clog2(SLOT_LONG);

    typedef logic [SLOT_LONG-1:0] slot_word_t;
    typedef logic [CNT_W-1:0]     bit_idx_t;

    typedef struct packed {
        logic long_slot;
        logic alt_edge;
        logic delayed;
    } pcm_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SLOT  = 2'd2
    } slot_state_t;

    function automatic bit_idx_t last_bit(input logic long_slot);
        return long_slot ? bit_idx_t'(SLOT_LONG - 1) : bit_idx_t'(SLOT_SHORT - 1);
    endfunction

    // Left-justified image for the transmit shifter: the top bit leaves first.
    function automatic slot_word_t tx_image(input slot_word_t w, input logic long_slot);
        slot_word_t keep;
        keep = ~slot_word_t'(0) << (SLOT_LONG - SAMPLE_BITS);
        return long_slot ? (w & keep) : (w << (SLOT_LONG - SLOT_SHORT));
    endfunction

    function automatic slot_word_t rx_image(input slot_word_t full, input logic long_slot);
        return long_slot ? full : (full & slot_word_t'({SLOT_SHORT{1'b1}}));
    endfunction

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_pin,
    input  logic fs_pin,
    input  logic rx_pin,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic fs_rise,
    output logic rx_bit
);

    logic [STAGES-1:0] bclk_q, fs_q, rx_q;
    logic              bclk_d, fs_d;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    bclk_q <= '0;
                    fs_q   <= '0;
                    rx_q   <= '0;
                end else begin
                    bclk_q <= bclk_pin;
                    fs_q   <= fs_pin;
                    rx_q   <= rx_pin;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    bclk_q <= '0;
                    fs_q   <= '0;
                    rx_q   <= '0;
                end else begin
                    bclk_q <= {bclk_q[STAGES-2:0], bclk_pin};
                    fs_q   <= {fs_q[STAGES-2:0], fs_pin};
                    rx_q   <= {rx_q[STAGES-2:0], rx_pin};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d <= 1'b0;
            fs_d   <= 1'b0;
        end else begin
            bclk_d <= bclk_q[STAGES-1];
            fs_d   <= fs_q[STAGES-1];
        end
    end

    assign bclk_rise = bclk_q[STAGES-1] & ~bclk_d;
    assign bclk_fall = ~bclk_q[STAGES-1] & bclk_d;
    assign fs_rise   = fs_q[STAGES-1] & ~fs_d;
    assign rx_bit    = rx_q[STAGES-1];

endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
    import pcm_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pcm_mode_t mode_in,
    input  logic      bclk_rise,
    input  logic      bclk_fall,
    input  logic      fs_rise,
    output pcm_mode_t mode_q,
    output logic      tx_en,
    output logic      do_shift,
    output logic      do_capture,
    output logic      do_last
);

    slot_state_t state;
    bit_idx_t    cnt;
    logic        sampled;
    logic        launch_ev, smp_ev;

    assign launch_ev  = mode_q.alt_edge ? bclk_fall : bclk_rise;
    assign smp_ev     = mode_q.alt_edge ? bclk_rise : bclk_fall;
    assign do_capture = (state == ST_SLOT) && smp_ev && !fs_rise;
    assign do_last    = do_capture && (cnt == last_bit(mode_q.long_slot));
    assign do_shift   = (state == ST_SLOT) && launch_ev && sampled && !fs_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sampled <= 1'b0;
            tx_en   <= 1'b0;
            mode_q  <= '0;
        end else if (fs_rise) begin
            mode_q  <= mode_in;
            cnt     <= '0;
            sampled <= 1'b0;
            state   <= mode_in.delayed ? ST_ARMED : ST_SLOT;
            tx_en   <= !mode_in.delayed;
        end else begin
            case (state)
                ST_ARMED: begin
                    if (launch_ev) begin
                        state <= ST_SLOT;
                        tx_en <= 1'b1;
                    end
                end
                ST_SLOT: begin
                    if (do_last) begin
                        state   <= ST_IDLE;
                        tx_en   <= 1'b0;
                        cnt     <= '0;
                        sampled <= 1'b0;
                    end else if (do_capture) begin
                        cnt     <= cnt + 1'b1;
                        sampled <= 1'b1;
                    end else if (do_shift) begin
                        sampled <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_oe_fall_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_en) |-> $past(smp_ev || fs_rise));

    assert_count_in_slot_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOT) |-> (cnt <= last_bit(mode_q.long_slot)));

    assert_armed_needs_delay_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED) |-> (mode_q.delayed && !tx_en));

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       long_slot,
    input  slot_word_t word_in,
    input  logic       shift,
    input  logic       en,
    output logic       tx_data
);

    slot_word_t shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= tx_image(word_in, long_slot);
        end else if (shift) begin
            shreg <= {shreg[SLOT_LONG-2:0], 1'b0};
        end
    end

    assign tx_data = en & shreg[SLOT_LONG-1];

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit,
    input  logic       capture,
    input  logic       last,
    input  logic       long_slot,
    output slot_word_t rx_word,
    output logic       rx_valid
);

    logic [SLOT_LONG-2:0] shreg;
    slot_word_t           full;

    assign full = {shreg, rx_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= last;
            if (capture) shreg   <= full[SLOT_LONG-2:0];
            if (last)    rx_word <= rx_image(full, long_slot);
        end
    end

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
    import pcm_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bclk_in,
    input  logic                 fsync_in,
    input  logic                 rx_in,
    input  logic [SLOT_LONG-1:0] tx_word,
    input  logic                 slot_long,
    input  logic                 edge_alt,
    input  logic                 frame_delayed,
    output logic                 tx_data,
    output logic                 tx_oe,
    output logic [SLOT_LONG-1:0] rx_word,
    output logic                 rx_valid
);

    pcm_mode_t mode_in, mode_q;
    logic      bclk_rise, bclk_fall, fs_rise, rx_bit;
    logic      do_shift, do_capture, do_last;

    assign mode_in = '{long_slot: slot_long, alt_edge: edge_alt, delayed: frame_delayed};

    pcm_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst),
        .bclk_pin(bclk_in), .fs_pin(fsync_in), .rx_pin(rx_in),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .fs_rise(fs_rise), .rx_bit(rx_bit)
    );

    pcm_slot_ctrl ctrl_i (
        .clk(clk), .rst(rst), .mode_in(mode_in),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .fs_rise(fs_rise),
        .mode_q(mode_q), .tx_en(tx_oe),
        .do_shift(do_shift), .do_capture(do_capture), .do_last(do_last)
    );

    pcm_tx_shift tx_i (
        .clk(clk), .rst(rst), .load(fs_rise), .long_slot(slot_long),
        .word_in(tx_word), .shift(do_shift), .en(tx_oe), .tx_data(tx_data)
    );

    pcm_rx_shift rx_i (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .capture(do_capture),
        .last(do_last), .long_slot(mode_q.long_slot),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_oe && !rx_valid && rx_word == '0));

    assert_bit_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_oe && $past(tx_oe) && !$past(do_shift) && !$past(fs_rise)) |-> $stable(tx_data));

    assert_abort_silent_R10: assert property (@(posedge clk) disable iff (rst)
        $past(fs_rise) |-> !rx_valid);

endmodule

// File: tb/pcm_frame_port_tb_top.sv
`timescale 1ns/1ps
module pcm_frame_port_tb_top;

    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lvl = 1'b0;
    logic        fsync_in = 1'b0, rx_in = 1'b0;
    logic [15:0] tx_word = '0;
    logic        slot_long = 1'b1, edge_alt = 1'b0, frame_delayed = 1'b0;
    logic        bclk_in, tx_data, tx_oe, rx_valid;
    logic [15:0] rx_word;

    int          n_checks = 0, n_fail = 0, vcount = 0;
    logic [15:0] vword = '0;
    bit          done = 0;

    always #2.5 clk = ~clk;
    assign bclk_in = lvl ^ edge_alt;

    pcm_frame_port dut_i (
        .clk(clk), .rst(rst), .bclk_in(bclk_in), .fsync_in(fsync_in), .rx_in(rx_in),
        .tx_word(tx_word), .slot_long(slot_long), .edge_alt(edge_alt),
        .frame_delayed(frame_delayed), .tx_data(tx_data), .tx_oe(tx_oe),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock model of the idle line and the publish strobe.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rx_valid === 1'b1) begin
                vcount++;
                vword = rx_word;
            end
            check((tx_oe === 1'b1) || (tx_data === 1'b0), "R8 line low while released",
                  {31'd0, tx_data}, 32'd0);
        end
    end

    task automatic frame(input int n, input bit dly, input bit alt,
                         input logic [15:0] txw, input logic [15:0] rxw,
                         input int cut, input bit flip, input string tag);
        logic [15:0] img, exp_rx;
        bit          exp_q[$];
        int          off, periods, v0;
        slot_long = (n == 16);
        edge_alt = alt;
        frame_delayed = dly;
        tx_word = txw;
        img = (n == 16) ? {txw[15:2], 2'b00} : {txw[7:0], 8'h00};
        for (int k = 0; k < n && k < cut; k++) exp_q.push_back(img[15-k]);
        exp_rx = (n == 16) ? rxw : {8'h00, rxw[7:0]};
        off = dly ? 1 : 0;
        periods = cut + off;
        v0 = vcount;
        repeat (2*H) @(negedge clk);
        for (int p = 0; p < periods; p++) begin
            lvl = 1'b1;
            fsync_in = (p == 0);
            rx_in = (p >= off && p - off < n) ? rxw[n-1-(p-off)] : 1'b0;
            if (flip && p == 3) begin
                slot_long = ~slot_long;
                tx_word = ~txw;
            end
            repeat (H-1) @(negedge clk);
            if (p >= off) begin
                bit e;
                e = exp_q.pop_front();
                check(tx_oe === 1'b1 && tx_data === e,
                      $sformatf("%s bit %0d (R3 R4 %s)", tag, p - off, dly ? "R7" : "R6"),
                      {30'd0, tx_oe, tx_data}, {30'd0, 1'b1, e});
            end else begin
                check(tx_oe === 1'b0, {tag, " R7 driver off before first launch"},
                      {31'd0, tx_oe}, 32'd0);
            end
            @(negedge clk);
            lvl = 1'b0;
            repeat (H) @(negedge clk);
        end
        if (cut >= n) begin
            lvl = 1'b1;
            fsync_in = 1'b0;
            rx_in = 1'b0;
            repeat (H-1) @(negedge clk);
            check(tx_oe === 1'b0, {tag, " R8 released after last bit"}, {31'd0, tx_oe}, 32'd0);
            @(negedge clk);
            lvl = 1'b0;
            repeat (H) @(negedge clk);
            check(vcount == v0 + 1, {tag, " R9 one strobe"}, vcount, v0 + 1);
            check(vword === exp_rx, {tag, " R9 received word"}, {16'd0, vword}, {16'd0, exp_rx});
            repeat (H) @(negedge clk);
            check(rx_word === exp_rx, {tag, " R9 word holds"}, {16'd0, rx_word}, {16'd0, exp_rx});
        end else begin
            check(vcount == v0, {tag, " R10 abandoned slot publishes nothing"}, vcount, v0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_oe === 1'b0 && tx_data === 1'b0 && rx_valid === 1'b0 && rx_word === 16'd0,
              "R1 reset state", {13'd0, tx_oe, tx_data, rx_valid, rx_word}, 32'd0);
        frame(16, 0, 0, 16'hA5C3, 16'h1234, 16, 0, "linear nd R5");
        frame(8,  0, 0, 16'h00B6, 16'hFF5A, 8,  0, "short nd");
        frame(16, 1, 0, 16'h7E81, 16'hC0DE, 16, 0, "linear delayed");
        frame(8,  1, 0, 16'h1269, 16'h3396, 8,  0, "short delayed");
        frame(16, 0, 1, 16'hF00F, 16'h8001, 16, 0, "linear alt R5");
        frame(8,  1, 1, 16'h00C5, 16'h00A3, 8,  0, "short delayed alt R5");
        frame(16, 0, 0, 16'h3C0F, 16'h5AA5, 16, 1, "latched R2");
        frame(16, 0, 0, 16'hFFFF, 16'hFFFF, 5,  0, "abort linear");
        frame(16, 0, 0, 16'h9249, 16'h6DB6, 16, 0, "after abort R10");
        frame(8,  1, 0, 16'h00FF, 16'h00FF, 3,  0, "abort short");
        frame(8,  1, 0, 16'h0053, 16'h00E4, 8,  0, "after abort short R10");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule